// File: doc/BRIEF.md
# Capture Timer

This block is a free-running up-counter with an input-capture function. A programmable prescaler divides the system clock into count ticks. On each tick the counter steps up by one until it matches a software-set reload value, after which it restarts at 0x0001 and keeps running. An external timer input is synchronised into the clock domain. When the selected edge of that input is seen, the current count is copied into a capture register. The counter is not disturbed by a capture.

Software reaches the block through a byte-wide register port. The port gives access to the control byte, the count, the reload value and the captured value. A one-cycle interrupt pulse marks capture events, reload events, or both, as chosen by a configuration field. A status bit in the control byte shows whether the most recent interrupt came from a capture or from a reload. Typical use is to clear the capture register, start the timer, and on each interrupt read the status bit and the captured count to timestamp input edges.

Top module: `cap_timer`

## Requirements
- R1: After reset, every register reads as follows: control (address 0) is 0x00, count (address 1 high byte, address 2 low byte) is 0x0001, reload (address 3 high, address 4 low) is 0xFFFF, capture (address 5 high, address 6 low) is 0x0000, and irq is low.
- R2: While the run bit (control bit 7) is 1, the count rises by one on each prescaled tick. The prescale field (control bits 2:0, value N) produces one tick every 2^N clock cycles.
- R3: A tick that finds the count equal to the reload value loads 0x0001 instead of incrementing. The interval between successive reload interrupts is therefore reload×2^N clock cycles.
- R4: When control bit 6 is 1, a rising edge of tmr_in causes a capture; when it is 0, a falling edge does. The capture register takes the count held just before the third rising clock edge after the pin change. The counter keeps its normal sequence through the capture.
- R5: An edge of the other polarity causes no capture and no capture interrupt.
- R6: The interrupt select field (control bits 5:4) works as follows. 00 and 11 enable interrupts for both sources, 01 for captures only, and 10 for reloads only. A masked event gives no interrupt, but a capture still updates the capture register.
- R7: irq goes high for exactly one clock cycle, in the cycle after the clock edge on which the enabled event occurs.
- R8: The status bit (control bit 3) is set by a capture interrupt and cleared by a reload interrupt. A capture wins when both occur on the same edge. Writes to this bit have no effect.
- R9: Writes to the count take effect only while the run bit is 0. Writes made while the counter runs are ignored. A stopped counter holds its value.
- R10: Software can write the capture register, for example to clear it to 0x0000. Edges on tmr_in while the run bit is 0 capture nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| tmr_in | input | 1 | External timer input |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The capture sweep toggles the timer input about two hundred times at every phase of a short reload period, under both polarities. Alternating matching and non-matching edges separates captures from ignored edges. Edges that land next to a wrap show that the capture is taken from the live count and that the status bit resolves capture against reload. A sweep of all eight prescale settings with a fixed reload measures the reload-to-reload interval and the tick spacing, so that a wrong divide or a wrong wrap value shows up as a different cycle count. Separate runs of each interrupt select value, together with writes to the count and status bits while running and while stopped, distinguish masking from suppression of the capture itself.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

   // register addresses
   localparam logic [2:0] ADR_CTRL   = 3'd0;
   localparam logic [2:0] ADR_CNT_H  = 3'd1;
   localparam logic [2:0] ADR_CNT_L  = 3'd2;
   localparam logic [2:0] ADR_RLD_H  = 3'd3;
   localparam logic [2:0] ADR_RLD_L  = 3'd4;
   localparam logic [2:0] ADR_CAP_H  = 3'd5;
   localparam logic [2:0] ADR_CAP_L  = 3'd6;

   // control byte bit positions
   localparam int CB_RUN  = 7;
   localparam int CB_RISE = 6;
   localparam int CB_SEL  = 4;
   localparam int CB_STAT = 3;

   typedef enum logic [1:0] {
      ISEL_BOTH   = 2'b00,
      ISEL_CAP    = 2'b01,
      ISEL_RLD    = 2'b10,
      ISEL_BOTH_B = 2'b11
   } isel_e;

   function automatic logic cap_irq_on(isel_e s);
      return s != ISEL_RLD;
   endfunction

   function automatic logic rld_irq_on(isel_e s);
      return s != ISEL_CAP;
   endfunction

endpackage

// File: rtl/cap_timer_edge.sv
module cap_timer_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic rise_sel,
   output logic edge_hit
);

   logic [STAGES-1:0] sync_q;
   logic              prev_q;
   logic              cur;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cap_timer_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign cur      = sync_q[STAGES-1];
   assign edge_hit = rise_sel ? (cur & ~prev_q) : (~cur & prev_q);

endmodule

// File: rtl/cap_timer_presc.sv
module cap_timer_presc #(
   parameter int PRE_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] sel,
   output logic             tick
);

   localparam int DIV_W = (1 << PRE_W) - 1;
   localparam logic [DIV_W-1:0] ALL_ONES = '1;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    div_q <= '0;
      else if (!run) div_q <= '0;
      else           div_q <= div_q + 1'b1;
   end

   // sel = N selects the lowest N bits of the divider
   assign mask = ALL_ONES >> (DIV_W - int'(sel));
   assign tick = run && ((div_q & mask) == mask);

endmodule

// File: rtl/cap_timer_core.sv
module cap_timer_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             cap_hit,
   input  logic             cap_irq_en,
   input  logic             rld_irq_en,
   input  logic             cnt_we_hi,
   input  logic             cnt_we_lo,
   input  logic             cap_we_hi,
   input  logic             cap_we_lo,
   input  logic [7:0]       wdata,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cap,
   output logic             status,
   output logic             irq
);

   localparam int HI_W = CNT_W - 8;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cap_q;
   logic             stat_q;
   logic             irq_q;
   logic             wrap;
   logic             take;
   logic             ev_cap;
   logic             ev_rld;

   assign wrap   = tick && (cnt_q == reload);
   assign take   = run && cap_hit;
   assign ev_cap = take && cap_irq_en;
   assign ev_rld = wrap && rld_irq_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= ONE;
      end else if (tick) begin
         cnt_q <= wrap ? ONE : cnt_q + ONE;
      end else if (!run) begin
         if (cnt_we_hi) cnt_q[CNT_W-1:8] <= wdata[HI_W-1:0];
         if (cnt_we_lo) cnt_q[7:0]       <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q <= '0;
      end else if (take) begin
         cap_q <= cnt_q;
      end else begin
         if (cap_we_hi) cap_q[CNT_W-1:8] <= wdata[HI_W-1:0];
         if (cap_we_lo) cap_q[7:0]       <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= ev_cap | ev_rld;
         if (ev_cap)      stat_q <= 1'b1;
         else if (ev_rld) stat_q <= 1'b0;
      end
   end

   assign cnt    = cnt_q;
   assign cap    = cap_q;
   assign status = stat_q;
   assign irq    = irq_q;

endmodule

// File: rtl/cap_timer.sv
module cap_timer
   import cap_timer_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PRE_W       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic [2:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       tmr_in,
   output logic       irq
);

   localparam int HI_W = CNT_W - 8;

   generate
      if (CNT_W < 9 || CNT_W > 16) begin : g_bad_cnt_w
         $error("cap_timer: CNT_W must lie in 9..16");
      end
      if (PRE_W < 1 || PRE_W > 3) begin : g_bad_pre_w
         $error("cap_timer: PRE_W must lie in 1..3");
      end
   endgenerate

   logic             run_q;
   logic             rise_q;
   isel_e            isel_q;
   logic [PRE_W-1:0] pre_q;
   logic [CNT_W-1:0] rld_q;

   logic             tick;
   logic             cap_hit;
   logic             cap_irq_en;
   logic             rld_irq_en;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cap;
   logic             status;
   logic             wr_ctrl;
   logic             cnt_we_hi;
   logic             cnt_we_lo;
   logic             cnt_we_any;
   logic             cap_we_hi;
   logic             cap_we_lo;
   logic [15:0]      cnt_w;
   logic [15:0]      rld_w;
   logic [15:0]      cap_w;

   assign wr_ctrl    = reg_wr && (reg_addr == ADR_CTRL);
   assign cnt_we_hi  = reg_wr && (reg_addr == ADR_CNT_H);
   assign cnt_we_lo  = reg_wr && (reg_addr == ADR_CNT_L);
   assign cnt_we_any = (cnt_we_hi || cnt_we_lo) && !run_q;
   assign cap_we_hi  = reg_wr && (reg_addr == ADR_CAP_H);
   assign cap_we_lo  = reg_wr && (reg_addr == ADR_CAP_L);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         rise_q <= 1'b0;
         isel_q <= ISEL_BOTH;
         pre_q  <= '0;
      end else if (wr_ctrl) begin
         run_q  <= reg_wdata[CB_RUN];
         rise_q <= reg_wdata[CB_RISE];
         isel_q <= isel_e'(reg_wdata[CB_SEL +: 2]);
         pre_q  <= reg_wdata[PRE_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rld_q <= '1;
      end else if (reg_wr) begin
         if (reg_addr == ADR_RLD_H) rld_q[CNT_W-1:8] <= reg_wdata[HI_W-1:0];
         if (reg_addr == ADR_RLD_L) rld_q[7:0]       <= reg_wdata;
      end
   end

   assign cap_irq_en = cap_irq_on(isel_q);
   assign rld_irq_en = rld_irq_on(isel_q);

   cap_timer_presc #(.PRE_W(PRE_W)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_q),
      .sel   (pre_q),
      .tick  (tick)
   );

   cap_timer_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (tmr_in),
      .rise_sel (rise_q),
      .edge_hit (cap_hit)
   );

   cap_timer_core #(.CNT_W(CNT_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run_q),
      .tick       (tick),
      .cap_hit    (cap_hit),
      .cap_irq_en (cap_irq_en),
      .rld_irq_en (rld_irq_en),
      .cnt_we_hi  (cnt_we_hi),
      .cnt_we_lo  (cnt_we_lo),
      .cap_we_hi  (cap_we_hi),
      .cap_we_lo  (cap_we_lo),
      .wdata      (reg_wdata),
      .reload     (rld_q),
      .cnt        (cnt),
      .cap        (cap),
      .status     (status),
      .irq        (irq)
   );

   assign cnt_w = 16'(cnt);
   assign rld_w = 16'(rld_q);
   assign cap_w = 16'(cap);

   always_comb begin
      unique case (reg_addr)
         ADR_CTRL:  reg_rdata = {run_q, rise_q, isel_q, status, 3'(pre_q)};
         ADR_CNT_H: reg_rdata = cnt_w[15:8];
         ADR_CNT_L: reg_rdata = cnt_w[7:0];
         ADR_RLD_H: reg_rdata = rld_w[15:8];
         ADR_RLD_L: reg_rdata = rld_w[7:0];
         ADR_CAP_H: reg_rdata = cap_w[15:8];
         ADR_CAP_L: reg_rdata = cap_w[7:0];
         default:   reg_rdata = 8'h00;
      endcase
   end

endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             tick,
   input logic             cap_hit,
   input logic             cap_irq_en,
   input logic             rld_irq_en,
   input logic             cnt_wr,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] reload,
   input logic [CNT_W-1:0] cap,
   input logic             status,
   input logic             irq
);

   // count steps by one on a tick that is not a wrap (R2)
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      run && tick && (cnt != reload) |=> cnt == CNT_W'($past(cnt) + 1));

   // no tick, no change while running (R2)
   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      run && !tick |=> $stable(cnt));

   // wrap to one (R3)
   p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      run && tick && (cnt == reload) |=> cnt == CNT_W'(1));

   // capture copies the live count (R4)
   p_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run && cap_hit |=> cap == $past(cnt));

   // interrupt only from an enabled event (R6, R7)
   p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past((run && cap_hit && cap_irq_en) ||
                    (run && tick && (cnt == reload) && rld_irq_en)));

   // status set by capture interrupt (R8)
   p_stat_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      run && cap_hit && cap_irq_en |=> status);

   // status cleared by a lone reload interrupt (R8)
   p_stat_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      run && tick && (cnt == reload) && rld_irq_en && !(cap_hit && cap_irq_en)
      |=> !status);

   // stopped counter holds unless written (R9)
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run && !cnt_wr |=> $stable(cnt));

endmodule

bind cap_timer cap_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run        (run_q),
   .tick       (tick),
   .cap_hit    (cap_hit),
   .cap_irq_en (cap_irq_en),
   .rld_irq_en (rld_irq_en),
   .cnt_wr     (cnt_we_any),
   .cnt        (cnt),
   .reload     (rld_q),
   .cap        (cap),
   .status     (status),
   .irq        (irq)
);

// File: tb/cap_timer_tb_top.sv
`timescale 1ns/100ps
module cap_timer_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       tmr_in = 1'b0;
   logic       irq;

   int  checks = 0;
   int  fails  = 0;
   int  cyc    = 0;
   bit  done   = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cap_timer dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .tmr_in    (tmr_in),
      .irq       (irq)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic wr(logic [2:0] a, logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic wr16(logic [2:0] ahi, logic [15:0] v);
      wr(ahi, v[15:8]);
      wr(3'(ahi + 1), v[7:0]);
   endtask

   task automatic rd(logic [2:0] a, output logic [7:0] d);
      reg_addr = a;
      #0.1;
      d = reg_rdata;
   endtask

   task automatic rd16(logic [2:0] ahi, output logic [15:0] v);
      logic [7:0] h, l;
      rd(ahi, h);
      rd(3'(ahi + 1), l);
      v = {h, l};
   endtask

   function automatic logic [15:0] nxt(logic [15:0] x, logic [15:0] r);
      return (x == r) ? 16'd1 : x + 16'd1;
   endfunction

   task automatic setup(logic [2:0] pre, logic [1:0] isel, logic rise,
                        logic [15:0] start, logic [15:0] rel);
      wr(3'd0, {1'b0, rise, isel, 1'b0, pre});
      wr16(3'd1, start);
      wr16(3'd3, rel);
      wr16(3'd5, 16'h0000);
      wr(3'd0, {1'b1, rise, isel, 1'b0, pre});
   endtask

   task automatic wait_irq(output int t, output bit ok);
      ok = 1'b0; t = 0;
      for (int k = 0; k < 2000; k++) begin
         @(negedge clk);
         if (irq) begin ok = 1'b1; t = cyc; break; end
      end
   endtask

   // capture sweep for one polarity (R4, R5, R7, R8)
   task automatic cap_sweep(logic rise, logic [15:0] rel);
      logic [15:0] c0, v, capv, old_cap, now;
      logic [7:0]  ctl;
      logic        stat, match;
      tmr_in = ~rise;
      repeat (4) @(negedge clk);
      setup(3'd0, 2'b00, rise, 16'd1, rel);
      stat = 1'b0;
      old_cap = 16'h0000;
      rd16(3'd1, c0);
      for (int i = 0; i < 200; i++) begin
         tmr_in = ~tmr_in;
         match  = (tmr_in == rise);
         v = nxt(nxt(c0, rel), rel);
         @(negedge clk);
         chk("R7 irq pulse ends / reload timing", irq, (c0 == rel));
         @(negedge clk);
         @(negedge clk);
         rd16(3'd5, capv);
         if (match) begin
            chk("R4 captured count", capv, v);
            chk("R7 capture irq", irq, 1'b1);
            stat = 1'b1;
         end else begin
            chk("R5 opposite edge leaves capture", capv, old_cap);
            chk("R5 opposite edge irq", irq, (v == rel));
            if (c0 == rel || nxt(c0, rel) == rel || v == rel) stat = 1'b0;
         end
         rd(3'd0, ctl);
         chk("R8 status bit", ctl[3], stat);
         old_cap = capv;
         rd16(3'd1, now);
         chk("R4 counter continues", now, nxt(v, rel));
         c0 = now;
      end
   endtask

   initial begin
      logic [7:0]  b;
      logic [15:0] w, c;
      int t1, t2, n_irq;
      bit ok;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      chk("R1 irq", irq, 1'b0);
      rd(3'd0, b);     chk("R1 control", b, 8'h00);
      rd16(3'd1, w);   chk("R1 count", w, 16'h0001);
      rd16(3'd3, w);   chk("R1 reload", w, 16'hFFFF);
      rd16(3'd5, w);   chk("R1 capture", w, 16'h0000);

      // R4 R5 R7 R8 capture sweeps, both polarities
      cap_sweep(1'b1, 16'h0023);
      cap_sweep(1'b0, 16'h0017);

      // R2 R3 prescale sweep
      for (int n = 0; n < 8; n++) begin
         setup(3'(n), 2'b00, 1'b1, 16'd1, 16'd5);
         wait_irq(t1, ok);
         chk("R3 reload irq seen", ok, 1'b1);
         rd16(3'd1, w); chk("R3 wrap to 0001", w, 16'h0001);
         rd(3'd0, b);   chk("R8 status after reload", b[3], 1'b0);
         if (n > 0) begin
            repeat ((1 << n) - 1) @(negedge clk);
            rd16(3'd1, w); chk("R2 no step before tick", w, 16'h0001);
            @(negedge clk);
         end else begin
            @(negedge clk);
         end
         rd16(3'd1, w); chk("R2 step on tick", w, 16'h0002);
         wait_irq(t2, ok);
         chk("R3 reload period", t2 - t1, 5 << n);
      end

      // R8 status write ignored
      wr(3'd0, 8'h08);
      rd(3'd0, b);
      chk("R8 status not writable", b, 8'h00);

      // R6 capture-only: no reload interrupts, capture interrupts kept
      tmr_in = 1'b0;
      setup(3'd0, 2'b01, 1'b1, 16'd1, 16'd8);
      n_irq = 0;
      for (int k = 0; k < 40; k++) begin @(negedge clk); if (irq) n_irq++; end
      chk("R6 capture-only masks reload", n_irq, 0);
      rd16(3'd1, c);
      tmr_in = 1'b1;
      repeat (3) @(negedge clk);
      chk("R6 capture-only irq", irq, 1'b1);
      rd16(3'd5, w);
      chk("R6 capture-only value", w, nxt(nxt(c, 16'd8), 16'd8));

      // R6 reload-only: capture updates register, no interrupt
      tmr_in = 1'b0;
      setup(3'd0, 2'b10, 1'b1, 16'd1, 16'h1000);
      rd16(3'd1, c);
      tmr_in = 1'b1;
      repeat (3) @(negedge clk);
      chk("R6 reload-only no capture irq", irq, 1'b0);
      rd16(3'd5, w);
      chk("R6 reload-only still captures", w, c + 16'd2);
      setup(3'd0, 2'b10, 1'b1, 16'd1, 16'd8);
      n_irq = 0;
      for (int k = 0; k < 40; k++) begin @(negedge clk); if (irq) n_irq++; end
      chk("R6 reload-only reload irqs", n_irq, 5);

      // R6 select 11 behaves as both
      tmr_in = 1'b0;
      setup(3'd0, 2'b11, 1'b1, 16'd1, 16'h1000);
      tmr_in = 1'b1;
      repeat (3) @(negedge clk);
      chk("R6 select 11 capture irq", irq, 1'b1);

      // R9 count write ignored while running
      rd16(3'd1, c);
      wr16(3'd1, 16'hABCD);
      rd16(3'd1, w);
      chk("R9 write ignored while running", w, c + 16'd2);

      // R9 write and hold while stopped
      wr(3'd0, 8'h40);
      wr16(3'd1, 16'h1234);
      rd16(3'd1, w);
      chk("R9 write while stopped", w, 16'h1234);
      repeat (6) @(negedge clk);
      rd16(3'd1, w);
      chk("R9 stopped count holds", w, 16'h1234);

      // R10 capture clear and no capture while stopped
      wr16(3'd5, 16'h0000);
      rd16(3'd5, w);
      chk("R10 capture cleared", w, 16'h0000);
      tmr_in = 1'b0;
      repeat (4) @(negedge clk);
      tmr_in = 1'b1;
      n_irq = 0;
      for (int k = 0; k < 6; k++) begin @(negedge clk); if (irq) n_irq++; end
      rd16(3'd5, w);
      chk("R10 no capture while stopped", w, 16'h0000);
      chk("R10 no irq while stopped", n_irq, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule